// File: doc/BRIEF.md
# Precise Taint Tracker for a Two-Way Select

This block is a two-way data selector with a separate taint bit on every input bit. It produces the selected data and a taint bit for each output bit. A shared select line, which can also be tainted, picks between two data words, bit by bit. Each output taint bit is set only when a tainted input could change that output bit through the gate that drives it.

Every lane is built from four gates: an inverter on the select, two two-input AND gates and one OR gate. Each gate has a shadow function beside it. The shadow function reads the gate's actual data inputs and their taint bits. It therefore uses the intermediate data wires of the functional circuit, and not only the inputs at the block's edge.

The taint is precise at each gate and is then composed gate by gate. An untainted value that controls a gate hides the taint on the other input of that gate: a 0 controls an AND gate and a 1 controls an OR gate. A flag output reports whether any output bit is tainted.

Top module: `glift_mux_tracker`

## Requirements
- R1: For every lane i, out_data[i] equals in_one[i] when sel is 1, and in_zero[i] when sel is 0, whatever the taint bits are.
- R2: When sel_taint is 0 and every bit of in_zero_taint and in_one_taint is 0, every bit of out_taint is 0 and any_taint is 0.
- R3: When sel_taint is 0, the data lane that is not selected has no effect on out_taint[i], whatever its value and taint. The AND gate fed by an untainted 0 hides that lane.
- R4: When sel is tainted and in_zero[i] and in_one[i] are both untainted 0, out_taint[i] is 0. When sel is tainted and the two untainted data bits differ, out_taint[i] is 1.
- R5: When sel is tainted and in_zero[i] and in_one[i] are both untainted 1, out_taint[i] is 1. Both AND outputs are tainted, so the OR gate cannot hide the taint, even though the true output does not depend on sel.
- R6: The inverter passes the select taint through unchanged. With sel tainted at 0, in_zero[i] an untainted 1 and in_one[i] an untainted 0, out_taint[i] is 1, because the taint reaches the output only through the inverted-select AND gate.
- R7: When sel_taint is 0, out_taint[i] equals the taint bit of the selected data lane.
- R8: any_taint is 1 exactly when at least one bit of out_taint is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 1 | Select: 1 picks in_one, 0 picks in_zero |
| sel_taint | input | 1 | Taint bit of sel |
| in_zero | input | WIDTH | Data chosen when sel is 0 |
| in_zero_taint | input | WIDTH | Taint bits of in_zero, one per bit |
| in_one | input | WIDTH | Data chosen when sel is 1 |
| in_one_taint | input | WIDTH | Taint bits of in_one, one per bit |
| out_data | output | WIDTH | Selected data |
| out_taint | output | WIDTH | Taint bit of each out_data bit |
| any_taint | output | 1 | OR of all out_taint bits |

## Verification
Two things can happen to one output bit in the same cycle. A tainted select can be pushing taint through both AND gates while a data lane is also tainted or is being hidden by an untainted controlling value. The bench provokes this by driving a tainted select together with data words whose lanes run through every mix of equal, unequal, tainted and untainted bits, at the same time, and in pseudo-random patterns.

Each cycle is judged against a model in the bench. For each gate, the model flips every subset of that gate's tainted inputs and marks the gate output as tainted if any flip changes it. The gate results are then chained in the same order as the circuit, so a lane that the bench expects to be over-flagged (R5) and a lane that it expects to be hidden (R3, R4) are told apart within one word.

// File: rtl/glift_pkg.sv
package glift_pkg;

    // A data bit travelling with its own taint bit.
    typedef struct packed {
        logic v;   // logic value
        logic t;   // 1 = tainted
    } tbit_t;

    typedef enum logic [1:0] {
        GATE_AND = 2'd0,
        GATE_OR  = 2'd1
    } gate_kind_e;

    // Value of the functional gate.
    function automatic logic gate_value(input gate_kind_e k, input logic a, input logic b);
        return (k == GATE_AND) ? (a & b) : (a | b);
    endfunction

    // Shadow logic: taint of a two-input gate output. The value of each
    // input is read, so an untainted controlling value hides the other taint.
    function automatic logic gate_shadow(input gate_kind_e k, input tbit_t a, input tbit_t b);
        logic pa;
        logic pb;
        // pa: a passes the b input through (a is at its non-controlling value)
        pa = (k == GATE_AND) ? a.v : ~a.v;
        pb = (k == GATE_AND) ? b.v : ~b.v;
        return (pa & b.t) | (pb & a.t) | (a.t & b.t);
    endfunction

endpackage

// File: rtl/glift_gate2.sv
module glift_gate2
    import glift_pkg::*;
#(
    parameter gate_kind_e KIND = GATE_AND
) (
    input  tbit_t a,
    input  tbit_t b,
    output tbit_t y
);

    always_comb begin
        y.v = gate_value(KIND, a.v, b.v);
        y.t = gate_shadow(KIND, a, b);
    end

    // R2: a gate with no tainted input never has a tainted output
    always_comb begin
        if (!a.t && !b.t) begin
            a_r2_gate_clean: assert (!y.t);
        end
    end

endmodule

// File: rtl/glift_inv.sv
module glift_inv
    import glift_pkg::*;
(
    input  tbit_t a,
    output tbit_t y
);

    // The taint follows the wire. Only the value is inverted.
    assign y.v = ~a.v;
    assign y.t = a.t;

endmodule

// File: rtl/glift_mux_lane.sv
module glift_mux_lane
    import glift_pkg::*;
(
    input  tbit_t s,
    input  tbit_t d0,
    input  tbit_t d1,
    output tbit_t y
);

    tbit_t s_n;
    tbit_t g0;
    tbit_t g1;

    glift_inv u_inv (
        .a (s),
        .y (s_n)
    );

    glift_gate2 #(.KIND(GATE_AND)) u_and0 (
        .a (d0),
        .b (s_n),
        .y (g0)
    );

    glift_gate2 #(.KIND(GATE_AND)) u_and1 (
        .a (d1),
        .b (s),
        .y (g1)
    );

    glift_gate2 #(.KIND(GATE_OR)) u_or (
        .a (g0),
        .b (g1),
        .y (y)
    );

    always_comb begin
        // R1: the lane selects data whatever the taint bits are
        a_r1_select: assert (y.v == (s.v ? d1.v : d0.v));
        // R3: with an untainted select, the unselected lane is hidden
        if (!s.t && !s.v && !d0.t) begin
            a_r3_hide_one: assert (!y.t);
        end
        if (!s.t && s.v && !d1.t) begin
            a_r3_hide_zero: assert (!y.t);
        end
        // R7: with an untainted select, the selected taint reaches the output
        if (!s.t) begin
            a_r7_follow: assert (y.t == (s.v ? d1.t : d0.t));
        end
    end

endmodule

// File: rtl/glift_mux_tracker.sv
module glift_mux_tracker
    import glift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             sel,
    input  logic             sel_taint,
    input  logic [WIDTH-1:0] in_zero,
    input  logic [WIDTH-1:0] in_zero_taint,
    input  logic [WIDTH-1:0] in_one,
    input  logic [WIDTH-1:0] in_one_taint,
    output logic [WIDTH-1:0] out_data,
    output logic [WIDTH-1:0] out_taint,
    output logic             any_taint
);

    localparam int LANES = WIDTH;

    tbit_t sel_tb;
    assign sel_tb = '{v: sel, t: sel_taint};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        tbit_t d0;
        tbit_t d1;
        tbit_t yo;
        assign d0 = '{v: in_zero[i], t: in_zero_taint[i]};
        assign d1 = '{v: in_one[i],  t: in_one_taint[i]};

        glift_mux_lane u_lane (
            .s  (sel_tb),
            .d0 (d0),
            .d1 (d1),
            .y  (yo)
        );

        assign out_data[i]  = yo.v;
        assign out_taint[i] = yo.t;
    end

    assign any_taint = |out_taint;

    // R2: no tainted input anywhere gives no taint anywhere
    always_comb begin
        if (!sel_taint && (in_zero_taint == '0) && (in_one_taint == '0)) begin
            a_r2_all_clean: assert (!any_taint && (out_taint == '0));
        end
    end

endmodule

// File: tb/glift_mux_tracker_test.sv
module glift_mux_tracker_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel = 1'b0;
    logic         sel_taint = 1'b0;
    logic [W-1:0] in_zero = '0;
    logic [W-1:0] in_zero_taint = '0;
    logic [W-1:0] in_one = '0;
    logic [W-1:0] in_one_taint = '0;
    logic [W-1:0] out_data;
    logic [W-1:0] out_taint;
    logic         any_taint;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    glift_mux_tracker #(.WIDTH(W)) uut (
        .sel          (sel),
        .sel_taint    (sel_taint),
        .in_zero      (in_zero),
        .in_zero_taint(in_zero_taint),
        .in_one       (in_one),
        .in_one_taint (in_one_taint),
        .out_data     (out_data),
        .out_taint    (out_taint),
        .any_taint    (any_taint)
    );

    // Brute-force gate model: 0 = AND, 1 = OR
    function automatic logic bf_val(input int op, input logic a, input logic b);
        if (op == 0) return a & b;
        return a | b;
    endfunction

    function automatic logic bf_taint(input int op, input logic av, input logic at,
                                      input logic bv, input logic bt);
        logic base;
        base = bf_val(op, av, bv);
        for (int fa = 0; fa < 2; fa++) begin
            for (int fb = 0; fb < 2; fb++) begin
                if ((fa == 1 && !at) || (fb == 1 && !bt)) continue;
                if (bf_val(op, av ^ fa[0], bv ^ fb[0]) != base) return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    logic [W-1:0] exp_data;
    logic [W-1:0] exp_taint;

    task automatic model();
        for (int i = 0; i < W; i++) begin
            logic nv, g0v, g0t, g1v, g1t;
            nv  = ~sel;
            g0v = in_zero[i] & nv;
            g0t = bf_taint(0, in_zero[i], in_zero_taint[i], nv, sel_taint);
            g1v = in_one[i] & sel;
            g1t = bf_taint(0, in_one[i], in_one_taint[i], sel, sel_taint);
            exp_data[i]  = sel ? in_one[i] : in_zero[i];
            exp_taint[i] = bf_taint(1, g0v, g0t, g1v, g1t);
        end
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Compare the model with all outputs; sample on the falling edge.
    task automatic compare(input string tag);
        @(negedge clk);
        model();
        chk({tag, " R1 data"}, out_data, exp_data);
        chk({tag, " taint"}, out_taint, exp_taint);
        chk({tag, " R8 flag"}, {{(W-1){1'b0}}, any_taint}, {{(W-1){1'b0}}, |exp_taint});
    endtask

    task automatic drive(input logic s, input logic st, input logic [W-1:0] z,
                         input logic [W-1:0] zt, input logic [W-1:0] o,
                         input logic [W-1:0] ot);
        @(posedge clk);
        sel = s; sel_taint = st;
        in_zero = z; in_zero_taint = zt; in_one = o; in_one_taint = ot;
    endtask

    logic done = 1'b0;

    initial begin
        // reset state: all inputs clean, outputs quiet
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset R2 taint", out_taint, '0);
        chk("reset R2 flag", {7'd0, any_taint}, 8'd0);

        // R2: clean inputs, assorted data
        drive(1'b1, 1'b0, 8'hA5, 8'h00, 8'h3C, 8'h00);
        compare("R2 clean");
        chk("R2 zero taint", out_taint, 8'h00);

        // R3: sel=0 untainted, in_one fully tainted -> hidden
        drive(1'b0, 1'b0, 8'h0F, 8'h00, 8'hFF, 8'hFF);
        compare("R3 hide one");
        chk("R3 out_taint", out_taint, 8'h00);

        // R3: sel=1 untainted, in_zero fully tainted -> hidden
        drive(1'b1, 1'b0, 8'h55, 8'hFF, 8'hAA, 8'h00);
        compare("R3 hide zero");
        chk("R3 out_taint", out_taint, 8'h00);

        // R7: untainted sel follows selected lane's taint
        drive(1'b0, 1'b0, 8'h33, 8'h5A, 8'hCC, 8'hFF);
        compare("R7 follow");
        chk("R7 out_taint", out_taint, 8'h5A);

        // R4: tainted sel, lanes: bits7:4 both 0, bits3:0 differ
        drive(1'b1, 1'b1, 8'h0C, 8'h00, 8'h03, 8'h00);
        compare("R4 select taint");
        chk("R4 out_taint", out_taint, 8'h0F);

        // R5: tainted sel, both data untainted 1
        drive(1'b0, 1'b1, 8'hF0, 8'h00, 8'hF0, 8'h00);
        compare("R5 reconverge");
        chk("R5 out_taint", out_taint, 8'hF0);

        // R6: sel tainted at 0, in_zero=1, in_one=0
        drive(1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h00);
        compare("R6 inverter");
        chk("R6 out_taint", out_taint, 8'hFF);

        // R8: single tainted lane raises the flag
        drive(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h10);
        compare("R8 single");
        chk("R8 flag", {7'd0, any_taint}, 8'd1);

        // pseudo-random mixes, tainted select half the time
        begin
            logic [31:0] lfsr;
            lfsr = 32'hACE1_1234;
            for (int n = 0; n < 300; n++) begin
                logic [31:0] r1, r2;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                r1 = lfsr * 32'd1103515245 + 32'd12345;
                r2 = r1 * 32'd69069 + 32'd1;
                drive(r1[0], r1[1], r1[15:8], r1[23:16] & r2[7:0], r2[15:8], r2[23:16] & r1[31:24]);
                compare("R1 R4 R5 R7 random");
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule